// File: doc/BRIEF.md
# Windowed Register File

This block is a general-purpose register file for a processor core in which procedure calls shift the register view rather than copying data to a stack. Software always addresses 32 registers with a 5-bit number. Eight of them are global and fixed. The other twenty-four form a sliding view into a circular store of windows. Each window owns sixteen physical registers, its inputs and its locals. Its outputs are the inputs of the next window up.

A call strobe moves the view one window forward, so the values a caller leaves in its output registers appear in the callee's input registers without any copy. A return strobe moves the view back. A resident-window counter detects when a call would reuse storage that still holds live data, or when a return would reach a window that is no longer resident. In either case the block raises a flag, leaves the pointer alone and ignores further calls and returns. It waits until outside logic moves one window to or from memory and acknowledges.

The block has two combinational read ports and one write port. Reads are write-first: a read of the register being written in the same cycle returns the new value.

Top module: `win_regfile`

## Requirements
- R1: After reset, curWin is 0, overflow and underflow are low, and exactly one window is resident.
- R2: Architectural numbers 0–7 are globals and keep their contents across window moves. Numbers 8–15 are the current window's outputs, 16–23 its locals, and 24–31 its inputs.
- R3: Register 0 always reads as zero on both ports, and writes to it are discarded.
- R4: A call (saveReq alone, no flag pending) advances curWin by one modulo NUM_WIN, which is sixteen physical registers. Output register 8+k of the caller then reads as input register 24+k of the callee, including when the pointer wraps from NUM_WIN-1 to 0.
- R5: A return (restoreReq alone, no flag pending) moves curWin back by one modulo NUM_WIN. The caller's locals and inputs read back unchanged.
- R6: When wrEn is high and a read port addresses the same nonzero register, that port returns wrData in the same cycle.
- R7: A write issued in the same cycle as a call or return lands in the window that was current before the move.
- R8: A call made while NUM_WIN-1 windows are resident sets overflow and leaves curWin unchanged.
- R9: A return made while one window is resident sets underflow and leaves curWin unchanged.
- R10: While overflow or underflow is high, saveReq and restoreReq have no effect on curWin or on the flags.
- R11: spillAck while overflow is high clears overflow and releases one resident window. fillAck while underflow is high clears underflow and adds one resident window. An acknowledge with no matching flag is ignored.
- R12: saveReq and restoreReq asserted in the same cycle are both ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Read port A architectural register number |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | 5 | Read port B architectural register number |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write architectural register number |
| wrData | input | DATA_W | Write data |
| saveReq | input | 1 | Call: move the window forward |
| restoreReq | input | 1 | Return: move the window back |
| spillAck | input | 1 | Outside logic has spilled one window |
| fillAck | input | 1 | Outside logic has filled one window |
| overflow | output | 1 | A call needs a spill first |
| underflow | output | 1 | A return needs a fill first |
| curWin | output | log2(NUM_WIN) | Current window pointer |

## Verification
Two pairs of functions can fall in the same cycle. The first is a write and a read of the same register. The bench holds wrEn with both read addresses equal to wrAddr and samples the read data before the edge, expecting the new value. The second is a write together with a call. The bench writes a local in the same cycle as saveReq, then returns and reads that local, expecting it in the caller's window rather than in the callee's. A simultaneous call and return, and acknowledges that arrive while the opposite flag is pending, are also driven and judged at curWin and the flag outputs.

// File: rtl/win_regfile_pkg.sv
package win_regfile_pkg;

  // Strobes from the occupancy control to the datapath
  typedef struct packed {
    logic advance;
    logic retreat;
  } winStrobe_t;

  // Decoding of architectural register number bits [4:3]
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } regGroup_t;

  localparam int WIN_REGS = 16;
  localparam int GRP_REGS = 8;

endpackage

// File: rtl/win_regfile_ctrl.sv
module win_regfile_ctrl
  import win_regfile_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       saveReq,
  input  logic       restoreReq,
  input  logic       spillAck,
  input  logic       fillAck,
  output logic       overflow,
  output logic       underflow,
  output winStrobe_t strobe
);

  localparam int CNT_W = $clog2(NUM_WIN) + 1;
  localparam logic [CNT_W-1:0] MAX_RES = CNT_W'(NUM_WIN - 1);
  localparam logic [CNT_W-1:0] MIN_RES = CNT_W'(1);

  logic [CNT_W-1:0] resCnt;
  logic ovfFlag, unfFlag;
  logic saveOnly, restoreOnly, frozen, full, last;
  logic spillTake, fillTake;

  always_comb begin
    saveOnly    = saveReq & ~restoreReq;
    restoreOnly = restoreReq & ~saveReq;
    frozen      = ovfFlag | unfFlag;
    full        = (resCnt == MAX_RES);
    last        = (resCnt == MIN_RES);
    spillTake   = spillAck & ovfFlag;
    fillTake    = fillAck & unfFlag;
    strobe.advance = saveOnly & ~frozen & ~full;
    strobe.retreat = restoreOnly & ~frozen & ~last;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCnt  <= MIN_RES;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (spillTake) begin
      ovfFlag <= 1'b0;
      resCnt  <= resCnt - 1'b1;
    end else if (fillTake) begin
      unfFlag <= 1'b0;
      resCnt  <= resCnt + 1'b1;
    end else if (saveOnly && !frozen) begin
      if (full) ovfFlag <= 1'b1;
      else      resCnt  <= resCnt + 1'b1;
    end else if (restoreOnly && !frozen) begin
      if (last) unfFlag <= 1'b1;
      else      resCnt  <= resCnt - 1'b1;
    end
  end

  assign overflow  = ovfFlag;
  assign underflow = unfFlag;

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resCnt >= MIN_RES) && (resCnt <= MAX_RES));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow || underflow) |-> !(strobe.advance || strobe.retreat));

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(saveReq));

  // R9
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underflow) |-> $past(restoreReq));

endmodule

// File: rtl/win_regfile_dp.sv
module win_regfile_dp
  import win_regfile_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  winStrobe_t                 strobe,
  input  logic [1:0][4:0]            rdAddr,
  output logic [1:0][DATA_W-1:0]     rdData,
  input  logic                       wrEn,
  input  logic [4:0]                 wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [$clog2(NUM_WIN)-1:0] curWin
);

  localparam int WP_W    = $clog2(NUM_WIN);
  localparam int DEPTH   = NUM_WIN * WIN_REGS;
  localparam int PHYS_W  = $clog2(DEPTH);
  localparam int OFF_OUT = 16;
  localparam int OFF_LOC = 8;

  logic [WP_W-1:0]   cwp;
  logic [DATA_W-1:0] winMem [DEPTH];
  logic [DATA_W-1:0] globMem [GRP_REGS];

  // Map an architectural number to a circular physical index
  function automatic logic [PHYS_W-1:0] physOf(input logic [WP_W-1:0] wp,
                                                input logic [4:0] arch);
    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] off;
    base = PHYS_W'(wp) << 4;
    unique case (regGroup_t'(arch[4:3]))
      GRP_OUT:   off = PHYS_W'(OFF_OUT) + PHYS_W'(arch[2:0]);
      GRP_LOCAL: off = PHYS_W'(OFF_LOC) + PHYS_W'(arch[2:0]);
      default:   off = PHYS_W'(arch[2:0]);
    endcase
    return base + off;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cwp <= '0;
    else if (strobe.advance) cwp <= cwp + 1'b1;
    else if (strobe.retreat) cwp <= cwp - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != 5'd0)) begin
      if (regGroup_t'(wrAddr[4:3]) == GRP_GLOBAL) globMem[wrAddr[2:0]] <= wrData;
      else                                        winMem[physOf(cwp, wrAddr)] <= wrData;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DATA_W-1:0] stored;
    always_comb begin
      if (regGroup_t'(rdAddr[p][4:3]) == GRP_GLOBAL) stored = globMem[rdAddr[p][2:0]];
      else                                          stored = winMem[physOf(cwp, rdAddr[p])];
      if (rdAddr[p] == 5'd0)                        rdData[p] = '0;
      else if (wrEn && (wrAddr == rdAddr[p]))       rdData[p] = wrData;
      else                                          rdData[p] = stored;
    end
  end

  assign curWin = cwp;

  // R4
  win_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curWin) |-> $past(strobe.advance || strobe.retreat));

  // R3
  zero_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[0] == 5'd0) |-> (rdData[0] == '0));

endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import win_regfile_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [4:0]                 rdAddrA,
  output logic [DATA_W-1:0]          rdDataA,
  input  logic [4:0]                 rdAddrB,
  output logic [DATA_W-1:0]          rdDataB,
  input  logic                       wrEn,
  input  logic [4:0]                 wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       saveReq,
  input  logic                       restoreReq,
  input  logic                       spillAck,
  input  logic                       fillAck,
  output logic                       overflow,
  output logic                       underflow,
  output logic [$clog2(NUM_WIN)-1:0] curWin
);

  winStrobe_t              strobe;
  logic [1:0][4:0]         rdAddr;
  logic [1:0][DATA_W-1:0]  rdData;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  win_regfile_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .spillAck(spillAck), .fillAck(fillAck),
    .overflow(overflow), .underflow(underflow),
    .strobe(strobe)
  );

  win_regfile_dp #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curWin(curWin)
  );

endmodule

// File: tb/win_regfile_bench.sv
`timescale 1ns/1ps
module win_regfile_bench;

  localparam int NW = 8;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_S = 2'd2, OP_T = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // Save/restore entries expect curWin in exp
  localparam vec_t VEC [16] = '{
    '{OP_W, 5'd3,  32'h0000_00A3, 32'h0},
    '{OP_W, 5'd8,  32'h0000_0011, 32'h0},
    '{OP_W, 5'd16, 32'h0000_0022, 32'h0},
    '{OP_R, 5'd8,  32'h0,         32'h0000_0011},
    '{OP_S, 5'd0,  32'h0,         32'd1},
    '{OP_R, 5'd24, 32'h0,         32'h0000_0011},
    '{OP_R, 5'd3,  32'h0,         32'h0000_00A3},
    '{OP_W, 5'd16, 32'h0000_0033, 32'h0},
    '{OP_W, 5'd8,  32'h0000_0044, 32'h0},
    '{OP_T, 5'd0,  32'h0,         32'd0},
    '{OP_R, 5'd16, 32'h0,         32'h0000_0022},
    '{OP_R, 5'd8,  32'h0,         32'h0000_0011},
    '{OP_S, 5'd0,  32'h0,         32'd1},
    '{OP_R, 5'd16, 32'h0,         32'h0000_0033},
    '{OP_R, 5'd24, 32'h0,         32'h0000_0011},
    '{OP_T, 5'd0,  32'h0,         32'd0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic wrEn = 0, saveReq = 0, restoreReq = 0, spillAck = 0, fillAck = 0;
  logic overflow, underflow;
  logic [2:0] curWin;
  int nChecks = 0, nErr = 0;

  always #2.5 clk = ~clk;

  win_regfile #(.NUM_WIN(NW), .DATA_W(32)) u_win_regfile (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .spillAck(spillAck), .fillAck(fillAck),
    .overflow(overflow), .underflow(underflow), .curWin(curWin)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock with the given strobes, cleared just after the edge
  task automatic cyc(input logic sv, input logic rs, input logic sa, input logic fa,
                     input logic we, input logic [4:0] wa, input logic [31:0] wd);
    @(negedge clk);
    saveReq = sv; restoreReq = rs; spillAck = sa; fillAck = fa;
    wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    #1;
    saveReq = 0; restoreReq = 0; spillAck = 0; fillAck = 0; wrEn = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rdAddrA = a; rdAddrB = a;
    #1;
    check({tag, " portA"}, rdDataA, exp);
    check({tag, " portB"}, rdDataB, exp);
  endtask

  task automatic flags(input logic o, input logic u, input logic [2:0] w, input string tag);
    #1;
    check({tag, " overflow"}, {31'b0, overflow}, {31'b0, o});
    check({tag, " underflow"}, {31'b0, underflow}, {31'b0, u});
    check({tag, " curWin"}, {29'b0, curWin}, {29'b0, w});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    flags(0, 0, 0, "R1 reset");

    // Vector table: R2 R4 R5
    for (int i = 0; i < 16; i++) begin
      case (VEC[i].op)
        OP_W: cyc(0, 0, 0, 0, 1, VEC[i].addr, VEC[i].data);
        OP_R: rd(VEC[i].addr, VEC[i].exp, $sformatf("R2/R4/R5 vec%0d", i));
        OP_S: begin cyc(1, 0, 0, 0, 0, 0, 0); flags(0, 0, VEC[i].exp[2:0], $sformatf("R4 vec%0d", i)); end
        default: begin cyc(0, 1, 0, 0, 0, 0, 0); flags(0, 0, VEC[i].exp[2:0], $sformatf("R5 vec%0d", i)); end
      endcase
    end

    // R3: register zero
    cyc(0, 0, 0, 0, 1, 5'd0, 32'hFFFF_FFFF);
    rd(5'd0, 32'h0, "R3 zero");

    // R6: write-first bypass
    @(negedge clk);
    wrEn = 1; wrAddr = 5'd5; wrData = 32'h55; rdAddrA = 5'd5; rdAddrB = 5'd5;
    #1;
    check("R6 bypass portA", rdDataA, 32'h55);
    check("R6 bypass portB", rdDataB, 32'h55);
    @(posedge clk); #1 wrEn = 0;
    rd(5'd5, 32'h55, "R6 after write");

    // R7: write together with a call uses the old window
    cyc(1, 0, 0, 0, 1, 5'd16, 32'h77);
    flags(0, 0, 1, "R7 save");
    cyc(0, 1, 0, 0, 0, 0, 0);
    rd(5'd16, 32'h77, "R7 local in caller");

    // R12: simultaneous call and return
    cyc(1, 1, 0, 0, 0, 0, 0);
    flags(0, 0, 0, "R12 both");

    // R9: underflow
    cyc(0, 1, 0, 0, 0, 0, 0);
    flags(0, 1, 0, "R9 underflow");
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    flags(0, 1, 0, "R10 frozen on underflow");
    cyc(0, 0, 1, 0, 0, 0, 0);
    flags(0, 1, 0, "R11 spillAck ignored");
    cyc(0, 0, 0, 1, 0, 0, 0);
    flags(0, 0, 0, "R11 fillAck");
    cyc(0, 1, 0, 0, 0, 0, 0);
    flags(0, 0, 7, "R5 wrap back");

    // R4: output wraps to window 0 inputs
    cyc(0, 0, 0, 0, 1, 5'd8, 32'h99);
    cyc(1, 0, 0, 0, 0, 0, 0);
    flags(0, 0, 0, "R4 wrap forward");
    rd(5'd24, 32'h99, "R4 wrap param");

    // R8: overflow after NW-1 resident
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, 0, 0, 0);
    flags(0, 0, 5, "R8 deep");
    cyc(1, 0, 0, 0, 0, 0, 0);
    flags(1, 0, 5, "R8 overflow");
    cyc(0, 1, 0, 0, 0, 0, 0);
    flags(1, 0, 5, "R10 frozen on overflow");
    cyc(0, 0, 0, 1, 0, 0, 0);
    flags(1, 0, 5, "R11 fillAck ignored");
    cyc(0, 0, 1, 0, 0, 0, 0);
    flags(0, 0, 5, "R11 spillAck");
    cyc(1, 0, 0, 0, 0, 0, 0);
    flags(0, 0, 6, "R11 save after spill");
    cyc(1, 0, 0, 0, 0, 0, 0);
    flags(1, 0, 6, "R8 overflow again");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule